// File: doc/BRIEF.md
# GPIO Pin Control Register Bank

This block controls a bank of general-purpose I/O pins (32 by default) from a small synchronous register port. For every pin it keeps an output data latch, a direction bit, a pull-disable bit, a two-bit function select and a sleep-hold bit. From these bits it drives an output enable, an output value and the pull controls to each pad. A read of the level register returns the pad levels, which are sampled once per clock.

Software changes the data latch and the direction through separate set and clear registers. A write to one of these changes only the bits written as 1, so two agents can control different pins without read-modify-write races. The pull direction has no register of its own: an enabled pull pulls up when the pin's data latch bit is 1 and pulls down when it is 0. When a pin is routed to one of three alternate functions, its output enable and output value come from that function's input vectors. A sleep request input forces every pin whose hold bit is 0 into an input with its pull enabled. Pins whose hold bit is 1 keep their configured state during sleep.

Top module: `gpio_bank`

## Requirements
- R1: After reset every pin is a GPIO input (pad_oe all 0). The data latch is 0, so pad_out and pad_pull_up are all 0. Pulls are enabled (pad_pull_en all 1). The pull, select-A, select-B and hold registers read 0.
- R2: A write to address 1 sets the latch bits written as 1, and a write to address 2 clears the latch bits written as 1. Latch bits written as 0 keep their value. In GPIO mode pad_out equals the latch.
- R3: A write to address 3 makes the pins written as 1 outputs, and a write to address 4 makes the pins written as 1 inputs. Other pins keep their direction. In GPIO mode pad_oe equals the direction bit.
- R4: A read of address 0 returns the pad levels. Each pad level is registered once per clock, so a level held for two cycles before the read strobe is returned.
- R5: Address 5 holds the pull-disable bits (1 = pull off). Outside a forced sleep, pad_pull_en is 1 exactly when the pull-disable bit is 0 and pad_oe is 0. pad_pull_up always equals the latch bit.
- R6: Address 6 (select A) and address 7 (select B) form the pin mode. Both 0 gives GPIO, A only gives function A, B only gives function B, and both give function C. In a function mode, pad_oe and pad_out come from that function's oe and out inputs for the pin.
- R7: Address 8 holds the hold bits. While sleep_req is 1, a pin with hold bit 0 has pad_oe 0 and pad_pull_en 1, and a pin with hold bit 1 behaves as if awake.
- R8: The registers at addresses 5, 6, 7 and 8 read back the last value written. Addresses 1 to 4 and unmapped addresses read 0. A write to address 0 changes no register and no pad output.
- R9: reg_rvalid is 1 in the cycle after a cycle with reg_rd at 1 and is 0 otherwise. reg_rdata carries the addressed value in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 4 | Word address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data, one bit per pin |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 32 | Read data |
| reg_rvalid | output | 1 | Read data valid |
| pad_in | input | 32 | Pad input levels |
| sleep_req | input | 1 | Sleep request |
| alt_a_oe | input | 32 | Function A output enables |
| alt_a_out | input | 32 | Function A output values |
| alt_b_oe | input | 32 | Function B output enables |
| alt_b_out | input | 32 | Function B output values |
| alt_c_oe | input | 32 | Function C output enables |
| alt_c_out | input | 32 | Function C output values |
| pad_oe | output | 32 | Pad output enable |
| pad_out | output | 32 | Pad output value |
| pad_pull_en | output | 32 | Pad pull enable |
| pad_pull_up | output | 32 | Pad pull direction (1 = up) |

## Verification
The hardest case to reach is sleep acting on pins that are in different modes at the same time. A forced pin must drop an output enable that comes from an alternate function and turn its pull back on, while a held neighbour keeps driving. To reach it, the bench writes select patterns that give the pins the four modes in rotation. It then sets mixed direction, latch, pull and hold patterns and toggles sleep_req. At each step it compares all four pad vectors bit by bit against a model built from the register values it wrote.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_LEVEL  = 4'd0;
    localparam logic [ADDR_W-1:0] A_LSET   = 4'd1;
    localparam logic [ADDR_W-1:0] A_LCLR   = 4'd2;
    localparam logic [ADDR_W-1:0] A_DOUT   = 4'd3;
    localparam logic [ADDR_W-1:0] A_DIN    = 4'd4;
    localparam logic [ADDR_W-1:0] A_PULLOFF = 4'd5;
    localparam logic [ADDR_W-1:0] A_SELA   = 4'd6;
    localparam logic [ADDR_W-1:0] A_SELB   = 4'd7;
    localparam logic [ADDR_W-1:0] A_HOLD   = 4'd8;

    typedef enum logic [1:0] {
        PM_GPIO = 2'b00,
        PM_FN_A = 2'b01,
        PM_FN_B = 2'b10,
        PM_FN_C = 2'b11
    } pin_mode_e;

    typedef struct packed {
        logic      latch;
        logic      dir;
        logic      pull_off;
        pin_mode_e mode;
        logic      hold;
    } pin_cfg_t;

    typedef struct packed {
        logic oe;
        logic out;
        logic pull_en;
        logic pull_up;
    } pad_drive_t;

    function automatic pin_mode_e decode_mode(input logic sel_a, input logic sel_b);
        return pin_mode_e'({sel_b, sel_a});
    endfunction

endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [NPINS-1:0]  reg_wdata,
    input  logic              reg_rd,
    output logic [NPINS-1:0]  reg_rdata,
    output logic              reg_rvalid,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  latch_q,
    output logic [NPINS-1:0]  dir_q,
    output logic [NPINS-1:0]  poff_q,
    output logic [NPINS-1:0]  sela_q,
    output logic [NPINS-1:0]  selb_q,
    output logic [NPINS-1:0]  hold_q
);

    logic [NPINS-1:0] level_q;
    logic [NPINS-1:0] rd_mux;

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= '0;
        end else begin
            level_q <= pad_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= '0;
            dir_q   <= '0;
            poff_q  <= '0;
            sela_q  <= '0;
            selb_q  <= '0;
            hold_q  <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                A_LSET:    latch_q <= latch_q | reg_wdata;
                A_LCLR:    latch_q <= latch_q & ~reg_wdata;
                A_DOUT:    dir_q   <= dir_q | reg_wdata;
                A_DIN:     dir_q   <= dir_q & ~reg_wdata;
                A_PULLOFF: poff_q  <= reg_wdata;
                A_SELA:    sela_q  <= reg_wdata;
                A_SELB:    selb_q  <= reg_wdata;
                A_HOLD:    hold_q  <= reg_wdata;
                default:   ;
            endcase
        end
    end

    always_comb begin
        case (reg_addr)
            A_LEVEL:   rd_mux = level_q;
            A_PULLOFF: rd_mux = poff_q;
            A_SELA:    rd_mux = sela_q;
            A_SELB:    rd_mux = selb_q;
            A_HOLD:    rd_mux = hold_q;
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_rvalid <= 1'b0;
            reg_rdata  <= '0;
        end else begin
            reg_rvalid <= reg_rd;
            if (reg_rd) begin
                reg_rdata <= rd_mux;
            end
        end
    end

endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
    import gpio_bank_pkg::*;
(
    input  pin_cfg_t   cfg,
    input  logic       sleep_req,
    input  logic [2:0] fn_oe,
    input  logic [2:0] fn_out,
    output pad_drive_t drv
);

    logic awake_oe;
    logic awake_out;
    logic forced;

    always_comb begin
        unique case (cfg.mode)
            PM_GPIO: begin awake_oe = cfg.dir;   awake_out = cfg.latch;  end
            PM_FN_A: begin awake_oe = fn_oe[0];  awake_out = fn_out[0];  end
            PM_FN_B: begin awake_oe = fn_oe[1];  awake_out = fn_out[1];  end
            PM_FN_C: begin awake_oe = fn_oe[2];  awake_out = fn_out[2];  end
            default: begin awake_oe = 1'b0;      awake_out = 1'b0;       end
        endcase
    end

    assign forced = sleep_req & ~cfg.hold;

    always_comb begin
        drv.out     = awake_out;
        drv.pull_up = cfg.latch;
        if (forced) begin
            drv.oe      = 1'b0;
            drv.pull_en = 1'b1;
        end else begin
            drv.oe      = awake_oe;
            drv.pull_en = ~awake_oe & ~cfg.pull_off;
        end
    end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [NPINS-1:0]  reg_wdata,
    input  logic              reg_rd,
    output logic [NPINS-1:0]  reg_rdata,
    output logic              reg_rvalid,
    input  logic [NPINS-1:0]  pad_in,
    input  logic              sleep_req,
    input  logic [NPINS-1:0]  alt_a_oe,
    input  logic [NPINS-1:0]  alt_a_out,
    input  logic [NPINS-1:0]  alt_b_oe,
    input  logic [NPINS-1:0]  alt_b_out,
    input  logic [NPINS-1:0]  alt_c_oe,
    input  logic [NPINS-1:0]  alt_c_out,
    output logic [NPINS-1:0]  pad_oe,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_pull_en,
    output logic [NPINS-1:0]  pad_pull_up
);

    logic [NPINS-1:0] latch_q;
    logic [NPINS-1:0] dir_q;
    logic [NPINS-1:0] poff_q;
    logic [NPINS-1:0] sela_q;
    logic [NPINS-1:0] selb_q;
    logic [NPINS-1:0] hold_q;

    gpio_regs #(.NPINS(NPINS)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .reg_addr   (reg_addr),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .reg_rd     (reg_rd),
        .reg_rdata  (reg_rdata),
        .reg_rvalid (reg_rvalid),
        .pad_in     (pad_in),
        .latch_q    (latch_q),
        .dir_q      (dir_q),
        .poff_q     (poff_q),
        .sela_q     (sela_q),
        .selb_q     (selb_q),
        .hold_q     (hold_q)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        pin_cfg_t   cfg;
        pad_drive_t drv;

        assign cfg.latch    = latch_q[i];
        assign cfg.dir      = dir_q[i];
        assign cfg.pull_off = poff_q[i];
        assign cfg.mode     = decode_mode(sela_q[i], selb_q[i]);
        assign cfg.hold     = hold_q[i];

        gpio_pin_cell u_cell (
            .cfg       (cfg),
            .sleep_req (sleep_req),
            .fn_oe     ({alt_c_oe[i], alt_b_oe[i], alt_a_oe[i]}),
            .fn_out    ({alt_c_out[i], alt_b_out[i], alt_a_out[i]}),
            .drv       (drv)
        );

        assign pad_oe[i]      = drv.oe;
        assign pad_out[i]     = drv.out;
        assign pad_pull_en[i] = drv.pull_en;
        assign pad_pull_up[i] = drv.pull_up;
    end

endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic [NPINS-1:0]  reg_wdata,
    input logic              reg_rd,
    input logic              reg_rvalid,
    input logic              sleep_req,
    input logic [NPINS-1:0]  pad_oe,
    input logic [NPINS-1:0]  pad_pull_en,
    input logic [NPINS-1:0]  latch_q,
    input logic [NPINS-1:0]  dir_q,
    input logic [NPINS-1:0]  hold_q
);

    p_latch_set_r2: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == A_LSET) |=> ((latch_q & $past(reg_wdata)) == $past(reg_wdata)));

    p_latch_keep_r2: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == A_LCLR) |=>
        ((latch_q & ~$past(reg_wdata)) == ($past(latch_q) & ~$past(reg_wdata))));

    p_dir_in_r3: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == A_DIN) |=> ((dir_q & $past(reg_wdata)) == '0));

    p_rvalid_r9: assert property (@(posedge clk) disable iff (rst)
        reg_rd |=> reg_rvalid);

    p_no_rvalid_r9: assert property (@(posedge clk) disable iff (rst)
        !reg_rd |=> !reg_rvalid);

    p_sleep_input_r7: assert property (@(posedge clk) disable iff (rst)
        sleep_req |-> ((pad_oe & ~hold_q) == '0 && (pad_pull_en | hold_q) == '1));

    p_pull_only_input_r5: assert property (@(posedge clk) disable iff (rst)
        (pad_oe & pad_pull_en) == '0);

endmodule

bind gpio_bank gpio_bank_chk #(.NPINS(NPINS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_addr    (reg_addr),
    .reg_wr      (reg_wr),
    .reg_wdata   (reg_wdata),
    .reg_rd      (reg_rd),
    .reg_rvalid  (reg_rvalid),
    .sleep_req   (sleep_req),
    .pad_oe      (pad_oe),
    .pad_pull_en (pad_pull_en),
    .latch_q     (latch_q),
    .dir_q       (dir_q),
    .hold_q      (hold_q)
);

// File: tb/sim_gpio_bank.sv
module sim_gpio_bank;

    localparam int CLK_PERIOD = 10;
    localparam int N = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [3:0]    reg_addr = '0;
    logic          reg_wr = 1'b0;
    logic [N-1:0]  reg_wdata = '0;
    logic          reg_rd = 1'b0;
    logic [N-1:0]  reg_rdata;
    logic          reg_rvalid;
    logic [N-1:0]  pad_in = '0;
    logic          sleep_req = 1'b0;
    logic [N-1:0]  a_oe = '0, a_out = '0, b_oe = '0, b_out = '0, c_oe = '0, c_out = '0;
    logic [N-1:0]  pad_oe, pad_out, pad_pull_en, pad_pull_up;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // bench's own copy of the written configuration
    logic [N-1:0] m_lat = '0, m_dir = '0, m_poff = '0, m_sa = '0, m_sb = '0, m_hold = '0;

    gpio_bank #(.NPINS(N)) u0 (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rd(reg_rd), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid), .pad_in(pad_in),
        .sleep_req(sleep_req), .alt_a_oe(a_oe), .alt_a_out(a_out), .alt_b_oe(b_oe),
        .alt_b_out(b_out), .alt_c_oe(c_oe), .alt_c_out(c_out), .pad_oe(pad_oe),
        .pad_out(pad_out), .pad_pull_en(pad_pull_en), .pad_pull_up(pad_pull_up)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [N-1:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [N-1:0] d, output logic v);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata; v = reg_rvalid;
    endtask

    task automatic set_lat(input logic [N-1:0] v);
        wr(4'd2, ~v); wr(4'd1, v); m_lat = v;
    endtask
    task automatic set_dir(input logic [N-1:0] v);
        wr(4'd4, ~v); wr(4'd3, v); m_dir = v;
    endtask

    // pad expectation derived from the requirement text, pin by pin
    task automatic check_pads(input string tag);
        logic [N-1:0] e_oe, e_out, e_pe;
        for (int i = 0; i < N; i++) begin
            int mode = {m_sb[i], m_sa[i]};
            logic o, v;
            case (mode)
                0: begin o = m_dir[i]; v = m_lat[i]; end
                1: begin o = a_oe[i];  v = a_out[i]; end
                2: begin o = b_oe[i];  v = b_out[i]; end
                default: begin o = c_oe[i]; v = c_out[i]; end
            endcase
            e_out[i] = v;
            if (sleep_req && !m_hold[i]) begin
                e_oe[i] = 1'b0; e_pe[i] = 1'b1;
            end else begin
                e_oe[i] = o; e_pe[i] = !o && !m_poff[i];
            end
        end
        #1;
        check({tag, " oe"}, pad_oe, e_oe);
        check({tag, " out"}, pad_out, e_out);
        check({tag, " pull_en"}, pad_pull_en, e_pe);
        check({tag, " pull_up"}, pad_pull_up, m_lat);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [N-1:0] d;
        logic v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check_pads("R1 reset");
        rd(4'd5, d, v); check("R1 pull reg", d, '0);
        rd(4'd6, d, v); check("R1 selA reg", d, '0);
        rd(4'd7, d, v); check("R1 selB reg", d, '0);
        rd(4'd8, d, v); check("R1 hold reg", d, '0);

        // R2 latch set/clear with write-one semantics
        wr(4'd1, 32'h0000_00F0); m_lat = 32'h0000_00F0;
        wr(4'd1, 32'h0F00_0000); m_lat |= 32'h0F00_0000;
        check_pads("R2 set");
        wr(4'd2, 32'h0000_0030); m_lat &= ~32'h0000_0030;
        check_pads("R2 clear");
        wr(4'd1, '0); wr(4'd2, '0);
        check_pads("R2 zero writes");

        // R3 direction set/clear
        wr(4'd3, 32'hFFFF_0000); m_dir = 32'hFFFF_0000;
        check_pads("R3 out");
        wr(4'd4, 32'h00FF_0000); m_dir &= ~32'h00FF_0000;
        check_pads("R3 in");

        // R4 pad level readback, R9 valid timing
        for (int k = 0; k < 6; k++) begin
            logic [N-1:0] p = 32'h9E37_79B9 * (k + 1) ^ (32'h1 << k);
            @(negedge clk); pad_in = p;
            @(negedge clk);
            rd(4'd0, d, v);
            check("R4 level", d, p);
            check("R9 rvalid high", {31'b0, v}, 32'd1);
            @(negedge clk);
            check("R9 rvalid low", {31'b0, reg_rvalid}, 32'd0);
        end

        // R8 readable registers and write-only ones
        wr(4'd5, 32'h1234_5678); m_poff = 32'h1234_5678;
        rd(4'd5, d, v); check("R8 pull readback", d, m_poff);
        wr(4'd8, 32'hA5A5_0FF0); m_hold = 32'hA5A5_0FF0;
        rd(4'd8, d, v); check("R8 hold readback", d, m_hold);
        rd(4'd1, d, v); check("R8 set reg reads 0", d, '0);
        rd(4'd4, d, v); check("R8 clr reg reads 0", d, '0);
        rd(4'd12, d, v); check("R8 unmapped reads 0", d, '0);
        wr(4'd0, 32'hFFFF_FFFF);
        rd(4'd5, d, v); check("R8 level write ignored", d, m_poff);
        check_pads("R8 level write ignored");

        // R5 pull with mixed directions and latch values
        set_lat(32'hCAFE_F00D); set_dir(32'h0F0F_3C3C);
        check_pads("R5 pull");
        wr(4'd5, 32'h0000_FFFF); m_poff = 32'h0000_FFFF;
        check_pads("R5 pull off");

        // R6 modes: uniform then rotating, R7 sleep over each
        for (int pat = 0; pat < 5; pat++) begin
            logic [N-1:0] sa, sb;
            case (pat)
                0: begin sa = '0; sb = '0; end
                1: begin sa = '1; sb = '0; end
                2: begin sa = '0; sb = '1; end
                3: begin sa = '1; sb = '1; end
                default: begin sa = 32'hAAAA_AAAA; sb = 32'hCCCC_CCCC; end
            endcase
            wr(4'd6, sa); m_sa = sa;
            wr(4'd7, sb); m_sb = sb;
            rd(4'd6, d, v); check("R8 selA readback", d, sa);
            rd(4'd7, d, v); check("R8 selB readback", d, sb);
            for (int s = 0; s < 3; s++) begin
                @(negedge clk);
                a_oe = 32'h3C96_A55A ^ (s * 32'h1111_1111);
                a_out = 32'h0F1E_2D3C + s;
                b_oe = 32'hF0F0_1234 ^ (pat * 32'h0101_0101);
                b_out = 32'h5555_AAAA ^ (s << 4);
                c_oe = 32'h8421_8421 * (s + 2);
                c_out = ~a_out;
                sleep_req = 1'b0;
                check_pads("R6 mode");
                sleep_req = 1'b1;
                check_pads("R7 sleep");
            end
            sleep_req = 1'b0;
            wr(4'd8, ~m_hold); m_hold = ~m_hold;
            sleep_req = 1'b1;
            check_pads("R7 sleep hold swapped");
            sleep_req = 1'b0;
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule